// File: doc/BRIEF.md
# Stepped-Frequency Sweep Sequencer

This block runs a stepped-frequency measurement. A host loads three values through a small write port: the tuning word of the first point, the tuning word added at each step, and the number of steps. A start strobe then launches the sweep. The block drives a 27-bit tuning word to a downstream synthesizer and waits a fixed number of settle cycles. It then asks the capture engine for one capture-and-transform pass and holds that request until the engine reports completion. At that point it latches the real and imaginary results and raises a point-ready flag.

The sweep moves to the next frequency only after the host acknowledges the point. The new tuning word is the previous one plus the increment, wrapping modulo 2^27. The point at step index i therefore carries the word start + i*increment mod 2^27. A sweep with a step count of N measures N+1 points. After the last point is acknowledged, the block pulses a sweep-complete flag for one cycle and returns to idle. The synthesizer, the converter, the transform engine and the host serial link are outside the block.

Top module: `sweep_seq`

## Requirements
- R1: After reset, `ftw` is 0 and `cap_req`, `point_ready`, `sweep_done`, `busy` and `armed` are all 0.
- R2: A write with `wr_addr` 0 sets the start word and `wr_addr` 1 sets the increment word, both taken from the low 27 bits of `wr_data`. `wr_addr` 2 sets the step count from the low `CNT_W` bits. A write to `wr_addr` 3 changes nothing.
- R3: A `start` sampled while idle makes `busy` 1 and `ftw` equal to the start word from the next cycle on.
- R4: After `ftw` takes a new value, `cap_req` stays 0 for `SETTLE_CYC` cycles and then rises. `cap_req` and `point_ready` are never high together.
- R5: `cap_req` stays high until `cap_done` is sampled. In the next cycle `cap_req` is 0, `point_ready` is 1, and `pt_re`/`pt_im` hold the `res_re`/`res_im` values sampled with `cap_done`.
- R6: `point_ready` and `ftw` stay unchanged until `ack` is sampled.
- R7: An `ack` on a point that is not the last one drops `point_ready`. One cycle later `ftw` has advanced by the increment and a new settle period begins.
- R8: Tuning-word arithmetic wraps modulo 2^27.
- R9: A step count of N yields exactly N+1 points. The `ack` of the last point makes `sweep_done` 1 for exactly one cycle, with `busy` 0, after which the block is idle.
- R10: A `start` sampled while a sweep is running has no effect on `ftw`, the handshakes or the point count.
- R11: Writes sampled while a sweep is running, or in its completion cycle, do not change the stored parameters.
- R12: `cap_done` sampled when no capture is requested, and `ack` sampled when no point is ready, have no effect.
- R13: A write sampled while idle sets `armed` to 1. `armed` falls when a sweep starts and is 0 after the sweep completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | 2 | Parameter select: 0 start, 1 increment, 2 step count, 3 none |
| wr_data | input | FTW_W (27) | Write value |
| start | input | 1 | Sweep launch strobe |
| cap_done | input | 1 | Capture-and-transform completion pulse |
| res_re | input | RES_W (16) | Real result, valid with `cap_done` |
| res_im | input | RES_W (16) | Imaginary result, valid with `cap_done` |
| ack | input | 1 | Host acknowledge of the ready point |
| ftw | output | FTW_W (27) | Tuning word to the synthesizer |
| cap_req | output | 1 | Capture request, held until `cap_done` |
| point_ready | output | 1 | Results of the current point are valid |
| pt_re | output | RES_W (16) | Latched real result |
| pt_im | output | RES_W (16) | Latched imaginary result |
| sweep_done | output | 1 | One-cycle sweep-complete pulse |
| busy | output | 1 | Sweep in progress |
| armed | output | 1 | Parameters written since the last sweep |

## Verification
A wrong step index shows up as a wrong point count. Either `sweep_done` arrives one `ack` early or late, or an extra settle period begins. The bench sees this at the acknowledge of the final point. A corrupted tuning-word register is visible on `ftw` in the first cycle of the following settle period. A settle counter that is off by one moves the rising edge of `cap_req` by one cycle, and every point checks that edge to the exact cycle. A state machine that leaks out of the capture or ready state drops `cap_req` or `point_ready` before its handshake. The bench sees that in the cycle right after the stray strobe.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_MEAS   = 3'd3,
    ST_READY  = 3'd4,
    ST_INCR   = 3'd5,
    ST_DONE   = 3'd6
  } sweep_st_e;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_DELTA = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;

  function automatic logic in_sweep(input sweep_st_e s);
    return (s == ST_SETTLE) || (s == ST_MEAS) || (s == ST_READY) || (s == ST_INCR);
  endfunction

endpackage

// File: rtl/sweep_regs.sv
module sweep_regs
  import sweep_pkg::*;
#(
  parameter int FTW_W = 27,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [FTW_W-1:0] wr_data,
  input  logic             lock,
  output logic [FTW_W-1:0] start_word,
  output logic [FTW_W-1:0] delta_word,
  output logic [CNT_W-1:0] step_count,
  output logic             wr_hit
);

  logic hit_start, hit_delta, hit_count;

  assign hit_start = wr_en && !lock && (wr_addr == SEL_START);
  assign hit_delta = wr_en && !lock && (wr_addr == SEL_DELTA);
  assign hit_count = wr_en && !lock && (wr_addr == SEL_COUNT);
  assign wr_hit    = hit_start || hit_delta || hit_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_word <= '0;
      delta_word <= '0;
      step_count <= '0;
    end else begin
      if (hit_start) start_word <= wr_data;
      if (hit_delta) delta_word <= wr_data;
      if (hit_count) step_count <= wr_data[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/sweep_tuner.sv
module sweep_tuner #(
  parameter int FTW_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [FTW_W-1:0] start_word,
  input  logic [FTW_W-1:0] delta_word,
  output logic [FTW_W-1:0] ftw
);

  // Modular advance: the carry out of the top bit is dropped.
  function automatic logic [FTW_W-1:0] advance(input logic [FTW_W-1:0] cur,
                                               input logic [FTW_W-1:0] inc);
    logic [FTW_W:0] wide;
    wide = {1'b0, cur} + {1'b0, inc};
    return wide[FTW_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    ftw <= '0;
    else if (load) ftw <= start_word;
    else if (step) ftw <= advance(ftw, delta_word);
  end

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_hit,
  input  logic             cap_done,
  input  logic             ack,
  input  logic [CNT_W-1:0] step_count,
  output logic             ev_start,
  output logic             ev_step,
  output logic             ev_cap,
  output logic             ev_ack,
  output logic             lock,
  output logic             cap_req,
  output logic             point_ready,
  output logic             sweep_done,
  output logic             busy,
  output logic             armed
);

  localparam int STW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [STW-1:0] SC_LAST = STW'(SETTLE_CYC - 1);

  sweep_st_e        st, st_nx;
  logic [CNT_W-1:0] idx;
  logic [STW-1:0]   scnt;
  logic             last_point, settle_end;

  assign ev_start   = start && ((st == ST_IDLE) || (st == ST_PROG));
  assign ev_cap     = cap_done && (st == ST_MEAS);
  assign ev_ack     = ack && (st == ST_READY);
  assign ev_step    = (st == ST_INCR);
  assign last_point = (idx == step_count);
  assign settle_end = (st == ST_SETTLE) && (scnt == SC_LAST);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (ev_start) st_nx = ST_SETTLE;
                 else if (wr_hit) st_nx = ST_PROG;
      ST_PROG:   if (ev_start) st_nx = ST_SETTLE;
      ST_SETTLE: if (settle_end) st_nx = ST_MEAS;
      ST_MEAS:   if (ev_cap) st_nx = ST_READY;
      ST_READY:  if (ev_ack) st_nx = last_point ? ST_DONE : ST_INCR;
      ST_INCR:   st_nx = ST_SETTLE;
      ST_DONE:   st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      scnt <= '0;
    end else begin
      st <= st_nx;
      if (ev_start)     idx <= '0;
      else if (ev_step) idx <= idx + 1'b1;
      if (ev_start || ev_step)  scnt <= '0;
      else if (st == ST_SETTLE) scnt <= scnt + 1'b1;
    end
  end

  assign busy        = in_sweep(st);
  assign lock        = busy || (st == ST_DONE);
  assign cap_req     = (st == ST_MEAS);
  assign point_ready = (st == ST_READY);
  assign sweep_done  = (st == ST_DONE);
  assign armed       = (st == ST_PROG);

endmodule

// File: rtl/sweep_seq.sv
module sweep_seq #(
  parameter int FTW_W      = 27,
  parameter int CNT_W      = 8,
  parameter int RES_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [FTW_W-1:0] wr_data,
  input  logic             start,
  input  logic             cap_done,
  input  logic [RES_W-1:0] res_re,
  input  logic [RES_W-1:0] res_im,
  input  logic             ack,
  output logic [FTW_W-1:0] ftw,
  output logic             cap_req,
  output logic             point_ready,
  output logic [RES_W-1:0] pt_re,
  output logic [RES_W-1:0] pt_im,
  output logic             sweep_done,
  output logic             busy,
  output logic             armed
);

  logic [FTW_W-1:0] start_word, delta_word;
  logic [CNT_W-1:0] step_count;
  logic             wr_hit, lock;
  logic             ev_start, ev_step, ev_cap, ev_ack;

  sweep_regs #(.FTW_W(FTW_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock(lock), .start_word(start_word), .delta_word(delta_word),
    .step_count(step_count), .wr_hit(wr_hit)
  );

  sweep_ctrl #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_hit(wr_hit), .cap_done(cap_done),
    .ack(ack), .step_count(step_count), .ev_start(ev_start), .ev_step(ev_step),
    .ev_cap(ev_cap), .ev_ack(ev_ack), .lock(lock), .cap_req(cap_req),
    .point_ready(point_ready), .sweep_done(sweep_done), .busy(busy), .armed(armed)
  );

  sweep_tuner #(.FTW_W(FTW_W)) u_tuner (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .step(ev_step),
    .start_word(start_word), .delta_word(delta_word), .ftw(ftw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt_re <= '0;
      pt_im <= '0;
    end else if (ev_cap) begin
      pt_re <= res_re;
      pt_im <= res_im;
    end
  end

endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk #(
  parameter int FTW_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_req,
  input logic             cap_done,
  input logic             point_ready,
  input logic             ack,
  input logic             sweep_done,
  input logic             busy,
  input logic [FTW_W-1:0] ftw,
  input logic             ev_start,
  input logic             ev_step
);

  a_r3_start_enters_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy && !cap_req && !point_ready);

  a_r4_handshakes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_req && point_ready));

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req && !cap_done |=> cap_req);

  a_r5_ready_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(point_ready) |-> $past(cap_done));

  a_r6_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    point_ready && !ack |=> point_ready && $stable(ftw));

  a_r7_word_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ev_step |=> $stable(ftw));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> !busy ##1 !sweep_done);

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_start);

endmodule

bind sweep_seq sweep_seq_chk #(.FTW_W(FTW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_done(cap_done),
  .point_ready(point_ready), .ack(ack), .sweep_done(sweep_done), .busy(busy),
  .ftw(ftw), .ev_start(ev_start), .ev_step(ev_step)
);

// File: tb/test_sweep_seq.sv
module test_sweep_seq;

  localparam int FTW_W  = 27;
  localparam int CNT_W  = 8;
  localparam int RES_W  = 16;
  localparam int SETTLE = 4;
  localparam logic [FTW_W-1:0] MASK = '1;

  localparam int NV = 4;
  localparam logic [FTW_W-1:0] V_START [NV] = '{27'h0001000, 27'h5555555, 27'h7FFFF00, 27'h1234567};
  localparam logic [FTW_W-1:0] V_DELTA [NV] = '{27'h0000100, 27'h0ABCDEF, 27'h0000080, 27'h0000000};
  localparam int               V_COUNT [NV] = '{3, 2, 4, 0};
  localparam bit               V_POKE  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [FTW_W-1:0] wr_data = '0;
  logic start = 1'b0, cap_done = 1'b0, ack = 1'b0;
  logic [RES_W-1:0] res_re = '0, res_im = '0;
  logic [FTW_W-1:0] ftw;
  logic cap_req, point_ready, sweep_done, busy, armed;
  logic [RES_W-1:0] pt_re, pt_im;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sweep_seq #(.FTW_W(FTW_W), .CNT_W(CNT_W), .RES_W(RES_W), .SETTLE_CYC(SETTLE)) i_sweep_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .cap_done(cap_done), .res_re(res_re), .res_im(res_im), .ack(ack),
    .ftw(ftw), .cap_req(cap_req), .point_ready(point_ready), .pt_re(pt_re), .pt_im(pt_im),
    .sweep_done(sweep_done), .busy(busy), .armed(armed)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [FTW_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  // Wait out the settle period that began at the last edge; check the cap_req edge.
  task automatic settle(input logic [FTW_W-1:0] exp_w, input string tag);
    chk(ftw == exp_w, tag, 32'(ftw), 32'(exp_w));
    for (int j = 1; j < SETTLE; j++) begin
      chk(cap_req == 1'b0, "R4 settle low", 32'(cap_req), 0);
      tick();
    end
    chk(cap_req == 1'b0, "R4 settle low", 32'(cap_req), 0);
    tick();
    chk(cap_req == 1'b1, "R4 request after settle", 32'(cap_req), 1);
  endtask

  task automatic run_sweep(input logic [FTW_W-1:0] s, input logic [FTW_W-1:0] d,
                           input int n, input bit poke);
    logic [FTW_W-1:0] exp_w;
    logic [RES_W-1:0] re_v, im_v;
    wr(2'd0, s);
    chk(armed == 1'b1, "R13 armed after write", 32'(armed), 1);
    wr(2'd1, d);
    wr(2'd2, FTW_W'(n));
    wr(2'd3, 27'h7FFFFFF);  // R2: no register at this address
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", 32'(busy), 1);
    chk(armed == 1'b0, "R13 armed cleared", 32'(armed), 0);
    exp_w = s;
    settle(exp_w, "R3 first word");
    for (int p = 0; p <= n; p++) begin
      if (poke) begin
        ack = 1'b1; tick(); ack = 1'b0;
        chk(cap_req == 1'b1 && point_ready == 1'b0, "R12 stray ack in capture",
            32'({cap_req, point_ready}), 32'h2);
      end
      for (int w = 0; w < (p % 3); w++) begin
        tick();
        chk(cap_req == 1'b1, "R5 request held", 32'(cap_req), 1);
      end
      re_v = RES_W'(16'h1000 + p * 16'h0111);
      im_v = RES_W'(16'hA000 - p * 16'h0023);
      res_re = re_v; res_im = im_v; cap_done = 1'b1;
      tick();
      cap_done = 1'b0; res_re = '0; res_im = '0;
      chk(point_ready == 1'b1 && cap_req == 1'b0, "R5 ready after done",
          32'({point_ready, cap_req}), 32'h2);
      chk(pt_re == re_v && pt_im == im_v, "R5 results latched", {pt_re, pt_im}, {re_v, im_v});
      if (poke) begin
        cap_done = 1'b1; res_re = 16'hDEAD; res_im = 16'hBEEF;
        tick();
        cap_done = 1'b0;
        chk(pt_re == re_v && pt_im == im_v, "R12 stray done ignored", {pt_re, pt_im}, {re_v, im_v});
        start = 1'b1; tick(); start = 1'b0;
        chk(ftw == exp_w && point_ready == 1'b1, "R10 start ignored", 32'(ftw), 32'(exp_w));
        wr(2'd0, 27'h0000000);
        wr(2'd1, 27'h0000001);
        wr(2'd2, 27'h00000FF);
      end
      tick();
      chk(point_ready == 1'b1 && ftw == exp_w, "R6 held without ack", 32'(ftw), 32'(exp_w));
      ack = 1'b1;
      tick();
      ack = 1'b0;
      chk(point_ready == 1'b0, "R7 ready drops on ack", 32'(point_ready), 0);
      if (p == n) begin
        chk(sweep_done == 1'b1 && busy == 1'b0, "R9 done pulse", 32'({sweep_done, busy}), 32'h2);
        wr(2'd0, 27'h0ABCDEF);  // R11: completion-cycle write dropped
        chk(sweep_done == 1'b0 && busy == 1'b0, "R9 done one cycle", 32'({sweep_done, busy}), 0);
        chk(armed == 1'b0, "R13 not armed after sweep", 32'(armed), 0);
      end else begin
        chk(sweep_done == 1'b0, "R9 not done early", 32'(sweep_done), 0);
        tick();
        exp_w = (exp_w + d) & MASK;
        settle(exp_w, poke ? "R11 word after blocked writes" : "R7 advanced word");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(ftw == '0, "R1 reset word", 32'(ftw), 0);
    chk({cap_req, point_ready, sweep_done, busy, armed} == 5'b0, "R1 reset flags",
        32'({cap_req, point_ready, sweep_done, busy, armed}), 0);

    for (int v = 0; v < NV; v++)
      run_sweep(V_START[v], V_DELTA[v], V_COUNT[v], V_POKE[v]);

    // R8: explicit wrap point
    run_sweep(27'h7FFFFF0, 27'h0000020, 1, 1'b0);

    // R11: the dropped completion-cycle write left the start word untouched
    start = 1'b1; tick(); start = 1'b0;
    chk(ftw == 27'h7FFFFF0, "R11 completion write dropped", 32'(ftw), 32'h7FFFFF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule